// File: doc/BRIEF.md
# Reloadable Bus-Cycle Interrupt Timer

This block is a down-counting interrupt timer that sits on an 8-bit processor write bus. It counts one step per processor cycle, using a cycle-enable tick that arrives in the fast clock domain. Software stores a 16-bit start value through two byte-wide registers. It then writes a control register that arms the timer and chooses between periodic and single-shot operation.

When the count runs out, the block raises a level interrupt request. The request stays up until software writes the control register again. In periodic mode the counter refills from the stored start value and keeps running. In single-shot mode the timer disarms itself. The block offers no read-back path. Its only output is the interrupt level.

Top module: `bct_timer`

## Requirements
- R1: After a synchronous active-low reset, the interrupt output is low and the start value, counter, arm flag, periodic flag and pending flag are all zero. Arming the timer straight after reset, with no start-value write, never raises the interrupt.
- R2: A write to address 0x4020 replaces bits 7:0 of the start value, and a write to 0x4021 replaces bits 15:8. Neither write alters a count already in progress.
- R3: In a write to the control address 0x4022, data bit 0 is the arm flag and data bit 1 is the periodic flag. Every control write clears the pending interrupt on the next clock.
- R4: A control write with bit 0 set loads the counter from the start value. A control write with bit 0 clear forces the counter to zero, so later ticks raise nothing.
- R5: The counter moves down by one only on a clock where the tick is high, the timer is armed and the counter is nonzero. On any other clock without a control write, the counter holds its value.
- R6: With a start value N of 1 or more, the interrupt output goes high on the clock that follows the Nth tick after the arming control write, and not earlier.
- R7: When a decrement reaches zero with the periodic flag set, the counter refills from the start value and the interrupt recurs every N ticks. With the periodic flag clear, the timer disarms and raises nothing more until it is armed again.
- R8: Once high, the interrupt output stays high until the next control write, whatever the ticks do.
- R9: When a control write and a tick fall on the same clock, the control write wins and that tick is not counted.
- R10: A start value of zero with the timer armed never decrements and never raises the interrupt.
- R11: Writes to any other address, and clocks where the write strobe is low, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, valid for one clock |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| tick | input | 1 | Cycle-enable pulse, one count step per high clock |
| irq | output | 1 | Registered interrupt request level |

## Verification
Two situations are hard to reach from the ports. The first is a control write landing on the same clock as the tick that would have expired the count. The second is a change to the start value while a count is already running. Neither comes up by chance at a useful rate. Directed sequences place these collisions on exact clocks, including a control write coinciding with a tick and a start-value rewrite halfway through a count. A long random phase then mixes small start values, both modes and dense ticks, and a bench-side model predicts the interrupt level on every clock. The periodic refill leaves no trace at the ports while the interrupt is held, so it is watched by properties on the counter.

// File: rtl/bct_pkg.sv
// Package: shared types for the bus-cycle interrupt timer.
// Assumes: a control command is a single-clock event decoded from the bus.
package bct_pkg;

    // Decoded control-register write: strobe plus the two mode bits.
    typedef struct packed {
        logic wr;
        logic arm;
        logic periodic;
    } ctrl_cmd_t;

endpackage

// File: rtl/bct_addr_decode.sv
// Module: bct_addr_decode
// Turns a bus write into per-byte start-value enables and a control command.
// Assumes: the start-value bytes sit at consecutive addresses from RELOAD_BASE,
// least significant byte first, and the control register sits at CTRL_ADDR.
module bct_addr_decode #(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned NUM_BYTES   = 2,
    parameter int unsigned RELOAD_BASE = 32'h4020,
    parameter int unsigned CTRL_ADDR   = 32'h4022,
    parameter int unsigned ARM_BIT     = 0,
    parameter int unsigned PER_BIT     = 1
) (
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [NUM_BYTES-1:0]  lane_we,
    output bct_pkg::ctrl_cmd_t    cmd
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    // One enable per start-value byte lane.
    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane
        localparam logic [ADDR_W-1:0] LANE_A = ADDR_W'(RELOAD_BASE + i);
        assign lane_we[i] = wr_en && (wr_addr == LANE_A);
    end

    // Control command: strobe and mode bits taken from the write data.
    always_comb begin
        cmd.wr       = wr_en && (wr_addr == CTRL_A);
        cmd.arm      = wr_data[ARM_BIT];
        cmd.periodic = wr_data[PER_BIT];
    end

endmodule

// File: rtl/bct_reload_reg.sv
// Module: bct_reload_reg
// Holds the start value as byte lanes, each written on its own enable.
// Assumes: the start value is an exact multiple of the bus width.
module bct_reload_reg #(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned NUM_BYTES = 2,
    localparam int unsigned VAL_W    = DATA_W * NUM_BYTES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BYTES-1:0] lane_we,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [VAL_W-1:0]     reload_q
);

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
        // Store one byte of the start value when its lane is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                reload_q[i*DATA_W +: DATA_W] <= '0;
            else if (lane_we[i])
                reload_q[i*DATA_W +: DATA_W] <= wr_data;
        end
    end

endmodule

// File: rtl/bct_count_core.sv
// Module: bct_count_core
// Down-counter with arm and periodic flags, and a pending flag that drives irq.
// Assumes: a control command takes priority over a tick on the same clock.
module bct_count_core #(
    parameter int unsigned CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  bct_pkg::ctrl_cmd_t cmd,
    input  logic [CNT_W-1:0]   reload_q,
    output logic [CNT_W-1:0]   count_q,
    output logic               arm_q,
    output logic               per_q,
    output logic               pend_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic step;
    logic expire;

    // Decide whether this clock counts, and whether the count runs out.
    always_comb begin
        step   = tick && arm_q && (count_q != '0);
        expire = step && (count_q == ONE);
    end

    // Counter and flag update: control first, then counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            arm_q   <= 1'b0;
            per_q   <= 1'b0;
            pend_q  <= 1'b0;
        end else if (cmd.wr) begin
            pend_q  <= 1'b0;
            arm_q   <= cmd.arm;
            per_q   <= cmd.periodic;
            count_q <= cmd.arm ? reload_q : '0;
        end else if (expire) begin
            pend_q <= 1'b1;
            if (per_q) begin
                count_q <= reload_q;
            end else begin
                count_q <= '0;
                arm_q   <= 1'b0;
            end
        end else if (step) begin
            count_q <= count_q - ONE;
        end
    end

endmodule

// File: rtl/bct_timer.sv
// Module: bct_timer (top)
// Reloadable bus-cycle interrupt timer: address decode, start-value store,
// counting core. irq is the registered pending flag.
// Assumes: wr_en lasts one clock for each bus write, and tick marks a cycle step.
module bct_timer #(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned RELOAD_BASE = 32'h4020,
    parameter int unsigned CTRL_ADDR   = 32'h4022
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick,
    output logic              irq
);

    localparam int unsigned NUM_BYTES = CNT_W / DATA_W;

    logic [NUM_BYTES-1:0] lane_we;
    bct_pkg::ctrl_cmd_t   cmd;
    logic [CNT_W-1:0]     reload_q;
    logic [CNT_W-1:0]     count_q;
    logic                 arm_q;
    logic                 per_q;
    logic                 pend_q;

    bct_addr_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BYTES(NUM_BYTES),
        .RELOAD_BASE(RELOAD_BASE), .CTRL_ADDR(CTRL_ADDR),
        .ARM_BIT(0), .PER_BIT(1)
    ) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .lane_we(lane_we), .cmd(cmd)
    );

    bct_reload_reg #(
        .DATA_W(DATA_W), .NUM_BYTES(NUM_BYTES)
    ) u_rld (
        .clk(clk), .rst_n(rst_n), .lane_we(lane_we),
        .wr_data(wr_data), .reload_q(reload_q)
    );

    bct_count_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd(cmd),
        .reload_q(reload_q), .count_q(count_q), .arm_q(arm_q),
        .per_q(per_q), .pend_q(pend_q)
    );

    assign irq = pend_q;

endmodule

// File: rtl/bct_timer_chk.sv
// Module: bct_timer_chk
// Property checker for bct_timer, bound to every instance of the top.
module bct_timer_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             ctrl_wr,
    input logic             ctrl_arm,
    input logic             irq,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] reload_q,
    input logic             arm_q,
    input logic             per_q
);

    // R3: a control write clears the interrupt on the next clock
    a_r3_ctrl_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !irq);

    // R4: a control write that disarms leaves the counter at zero
    a_r4_disarm_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !ctrl_arm) |=> (count_q == '0));

    // R5: without a tick or a control write, the counter holds
    a_r5_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ctrl_wr) |=> $stable(count_q));

    // R6: the interrupt only rises after the counter sat at one
    a_r6_rise_from_one: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(count_q) == CNT_W'(1)));

    // R7: a periodic expiry refills from the start value
    a_r7_periodic_refill: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ctrl_wr && arm_q && per_q && count_q == CNT_W'(1))
        |=> (count_q == $past(reload_q)) && arm_q);

    // R7: a single-shot expiry disarms
    a_r7_oneshot_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ctrl_wr && arm_q && !per_q && count_q == CNT_W'(1))
        |=> !arm_q);

    // R8: the interrupt holds until a control write
    a_r8_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ctrl_wr) |=> irq);

    // R10: a zero count stays at zero without a control write
    a_r10_zero_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0 && !ctrl_wr) |=> (count_q == '0));

endmodule

bind bct_timer bct_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_wr(cmd.wr),
    .ctrl_arm(cmd.arm), .irq(irq), .count_q(count_q),
    .reload_q(reload_q), .arm_q(arm_q), .per_q(per_q)
);

// File: tb/bct_timer_tb.sv
module bct_timer_tb;

    localparam int CLK_P = 10;
    localparam logic [15:0] A_LO  = 16'h4020;
    localparam logic [15:0] A_HI  = 16'h4021;
    localparam logic [15:0] A_CTL = 16'h4022;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        tick = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    logic [15:0] m_rel, m_cnt;
    logic        m_arm, m_per, m_pend;

    always #(CLK_P/2) clk = ~clk;

    bct_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick(tick), .irq(irq)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: irq=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        m_rel = '0; m_cnt = '0; m_arm = 0; m_per = 0; m_pend = 0;
    endfunction

    // next-state of the model, written from the requirements
    function automatic void model_step(input logic we, input logic [15:0] a,
                                       input logic [7:0] d, input logic tk);
        logic [15:0] rel_n = m_rel;
        if (we && a == A_LO) rel_n[7:0]  = d;
        if (we && a == A_HI) rel_n[15:8] = d;
        if (we && a == A_CTL) begin
            m_pend = 0; m_arm = d[0]; m_per = d[1];
            m_cnt = d[0] ? m_rel : 16'h0;
        end else if (tk && m_arm && m_cnt != 0) begin
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) begin
                m_pend = 1;
                if (m_per) m_cnt = m_rel; else m_arm = 0;
            end
        end
        m_rel = rel_n;
    endfunction

    // one clock of stimulus; compares irq against the model afterwards
    task automatic step(input string tag, input logic we, input logic [15:0] a,
                        input logic [7:0] d, input logic tk);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; tick = tk;
        model_step(we, a, d, tk);
        @(posedge clk);
        #(CLK_P/4);
        check(tag, irq, m_pend);
    endtask

    task automatic wr(input string tag, input logic [15:0] a, input logic [7:0] d);
        step(tag, 1'b1, a, d, 1'b0);
    endtask

    task automatic ticks(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 1'b0, 16'h0, 8'h0, 1'b1);
    endtask

    task automatic setup(input string tag, input logic [15:0] v, input logic [7:0] c);
        wr(tag, A_LO, v[7:0]);
        wr(tag, A_HI, v[15:8]);
        wr(tag, A_CTL, c);
    endtask

    initial begin : watchdog
        #(CLK_P * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240613));
        model_reset();
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        check("R1 irq low in reset", irq, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R10: arm straight after reset, start value still zero
        wr("R1 arm after reset", A_CTL, 8'h01);
        ticks("R10 zero start never fires", 6);
        check("R10 no irq", irq, 1'b0);

        // R6: start value 3 fires on the third tick
        setup("R6 setup", 16'd3, 8'h01);
        ticks("R6 before expiry", 2);
        check("R6 not yet", irq, 1'b0);
        ticks("R6 expiry", 1);
        check("R6 fires on tick 3", irq, 1'b1);
        // R8 / R7: held high, one-shot does not refire
        ticks("R8 held", 7);
        check("R8 still high", irq, 1'b1);
        wr("R3 ack", A_CTL, 8'h00);
        check("R3 cleared by control write", irq, 1'b0);
        ticks("R7 one-shot silent", 8);
        check("R7 one-shot no refire", irq, 1'b0);

        // R7: periodic, recurs every 2 ticks after each ack
        setup("R7 setup", 16'd2, 8'h03);
        ticks("R7 period 1", 1);
        check("R7 not yet", irq, 1'b0);
        ticks("R7 period 1", 1);
        check("R7 first fire", irq, 1'b1);
        wr("R3 ack periodic", A_CTL, 8'h03);
        check("R3 clear periodic", irq, 1'b0);
        ticks("R7 period 2", 1);
        check("R7 not yet again", irq, 1'b0);
        ticks("R7 period 2", 1);
        check("R7 recurs", irq, 1'b1);

        // R4: disarming zeroes the counter
        setup("R4 setup", 16'd2, 8'h01);
        ticks("R4 one tick", 1);
        wr("R4 disarm", A_CTL, 8'h00);
        ticks("R4 after disarm", 6);
        check("R4 no fire after disarm", irq, 1'b0);

        // R2: start-value rewrite mid-count leaves the count alone
        setup("R2 setup", 16'd4, 8'h01);
        ticks("R2 first half", 2);
        wr("R2 rewrite low", A_LO, 8'd100);
        wr("R2 rewrite high", A_HI, 8'd1);
        ticks("R2 third", 1);
        check("R2 not yet", irq, 1'b0);
        ticks("R2 fourth", 1);
        check("R2 fires at old count", irq, 1'b1);

        // R9: control write with a tick on the same clock ignores the tick
        setup("R9 setup", 16'd2, 8'h00);
        step("R9 ctrl+tick", 1'b1, A_CTL, 8'h01, 1'b1);
        ticks("R9 tick 1", 1);
        check("R9 tick not counted", irq, 1'b0);
        ticks("R9 tick 2", 1);
        check("R9 fires on second tick", irq, 1'b1);

        // R5 / R11: no ticks and foreign writes change nothing
        setup("R5 setup", 16'd2, 8'h01);
        for (int i = 0; i < 5; i++) step("R5 idle", 1'b0, A_CTL, 8'h01, 1'b0);
        wr("R11 foreign", 16'h4023, 8'hFF);
        wr("R11 foreign", 16'h4122, 8'h00);
        ticks("R5 tick 1", 1);
        check("R5 held count", irq, 1'b0);
        ticks("R5 tick 2", 1);
        check("R5 fires after 2 ticks", irq, 1'b1);

        // random phase, small start values so expiries happen often
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] a;
            logic [7:0]  d;
            int sel = $urandom_range(0, 9);
            d = 8'($urandom);
            case (sel)
                0, 1: begin a = A_LO; d = 8'($urandom_range(0, 6)); end
                2:    begin a = A_HI; d = ($urandom_range(0, 7) == 0) ? 8'd1 : 8'd0; end
                3:    a = A_CTL;
                4:    a = 16'h4023;
                default: a = 16'($urandom);
            endcase
            step("R3/R5/R7 random", ($urandom_range(0, 5) == 0), a, d,
                 ($urandom_range(0, 9) < 7));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule